// File: doc/BRIEF.md
# Pulse Width Capture Unit with Trigger Reset

This block measures how long an external input stays low. The pin is first brought into the clock domain by a short synchronizer chain. It then passes through a noise filter that accepts a new level only after a run of identical samples. Both edges of the filtered level drive one free-running counter, which advances once per clock in which the prescaler's `tick_en` is high.

The falling edge has two effects. It loads the fall-capture register with the running count, and it clears the counter to zero in the same clock. The rising edge loads the rise-capture register. Because the counter was cleared at the start of the pulse, the rise-capture register holds the width of the most recent low pulse in ticks, and software has no arithmetic to do. The fall-capture register holds the count reached between two successive falling edges, which is the time between pulse starts.

Each channel has a capture enable, a capture flag, an overcapture flag and a clear input. With ticks every clock, a low input lasting L clocks yields L-1 in the rise register.

Top module: `pwcap_top`

## Requirements
- R1: After reset, both capture registers, both capture flags and both overcapture flags are zero.
- R2: A level on the synchronized input is accepted only after FILT_LEN consecutive clock samples equal to that level (8 by default). A low excursion of FILT_LEN-1 clocks causes no capture, and one of exactly FILT_LEN clocks is accepted.
- R3: On an accepted falling edge with its enable high, the fall register loads the counter value. With ticks every clock, this equals the number of clocks between the two pin falls minus one, taken modulo 2^CNT_W.
- R4: An accepted falling edge clears the counter to zero on the next clock, taking priority over a tick. With ticks every clock, a low input of L clocks leaves (L-1) mod 2^CNT_W in the rise register.
- R5: The counter advances by one only in clocks where `tick_en` is 1 and no falling edge is accepted, and otherwise holds its value. A pulse seen with `tick_en` held at 0 captures a width of 0.
- R6: A capture register and its flag change only when that channel's enable is 1. The counter is cleared by a falling edge whether or not the fall channel is enabled.
- R7: Each capture register keeps its value until the next accepted capture on its own channel.
- R8: A capture sets the channel flag. A clear input held for one clock drops that channel's flag and overcapture flag, unless a capture arrives in the same clock, in which case the flag stays set.
- R9: A capture that arrives while the channel flag is still set raises the overcapture flag, which stays set until that channel is cleared.
- R10: The counter wraps from 2^CNT_W-1 to 0, so a pulse longer than the counter range reports its width modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable from the prescaler |
| pin_in | input | 1 | Asynchronous measured input, idle high |
| cap_en_fall | input | 1 | Capture enable, falling-edge channel |
| cap_en_rise | input | 1 | Capture enable, rising-edge channel |
| clr_fall | input | 1 | Clear flags of the falling-edge channel |
| clr_rise | input | 1 | Clear flags of the rising-edge channel |
| cap_fall | output | CNT_W | Count latched at the last falling edge |
| cap_rise | output | CNT_W | Count latched at the last rising edge (pulse width) |
| flag_fall | output | 1 | Falling-edge capture flag |
| flag_rise | output | 1 | Rising-edge capture flag |
| ovr_fall | output | 1 | Falling-edge overcapture flag |
| ovr_rise | output | 1 | Rising-edge overcapture flag |

## Verification
The bench builds the block with CNT_W = 8, FILT_LEN = 8 and SYNC_STAGES = 2. The narrow counter brings the wrap within reach: a 300-clock pulse reports 43, which covers R10 without the 65536 clocks a 16-bit counter would need. The default filter length lets the bench place spikes of 7 and 8 clocks exactly on the acceptance boundary. With `tick_en` held high, every expected width and period follows directly from the bench's own cycle count.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
    localparam int NUM_CH  = 2;
    localparam int CH_FALL = 0;
    localparam int CH_RISE = 1;

    typedef struct packed {
        logic flag;
        logic ovr;
    } cap_flags_t;
endpackage

// File: rtl/pwcap_sync.sv
module pwcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int ST = (STAGES < 2) ? 2 : STAGES;

    logic [ST-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[ST-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[ST-1];
endmodule

// File: rtl/pwcap_filter.sv
module pwcap_filter #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall_o,
    output logic rise_o
);
    localparam int RUN_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
        logic             fall;
        logic             rise;
    } filt_t;

    filt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.fall = 1'b0;
        s_d.rise = 1'b0;
        if (din == s_q.lvl) begin
            s_d.run = '0;
        end else if (s_q.run == RUN_LAST) begin
            s_d.lvl  = din;
            s_d.run  = '0;
            s_d.fall = ~din;
            s_d.rise = din;
        end else begin
            s_d.run = s_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{lvl: 1'b1, run: '0, fall: 1'b0, rise: 1'b0};
        else        s_q <= s_d;
    end

    assign fall_o = s_q.fall;
    assign rise_o = s_q.rise;
endmodule

// File: rtl/pwcap_channel.sv
module pwcap_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             en,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             flag,
    output logic             ovr
);
    import pwcap_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        cap_flags_t       fl;
    } chan_t;

    chan_t s_d, s_q;
    logic  hit;

    always_comb begin
        hit        = evt & en;
        s_d        = s_q;
        s_d.cap    = hit ? cnt : s_q.cap;
        s_d.fl.flag = hit | (s_q.fl.flag & ~clr);
        s_d.fl.ovr  = ~clr & (s_q.fl.ovr | (hit & s_q.fl.flag));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cap  = s_q.cap;
    assign flag = s_q.fl.flag;
    assign ovr  = s_q.fl.ovr;
endmodule

// File: rtl/pwcap_top.sv
module pwcap_top #(
    parameter int CNT_W       = 16,
    parameter int FILT_LEN    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             pin_in,
    input  logic             cap_en_fall,
    input  logic             cap_en_rise,
    input  logic             clr_fall,
    input  logic             clr_rise,
    output logic [CNT_W-1:0] cap_fall,
    output logic [CNT_W-1:0] cap_rise,
    output logic             flag_fall,
    output logic             flag_rise,
    output logic             ovr_fall,
    output logic             ovr_rise
);
    import pwcap_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    logic pin_s;
    logic fall_evt, rise_evt;
    ctr_t c_d, c_q;

    pwcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_s)
    );

    pwcap_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_s),
        .fall_o(fall_evt),
        .rise_o(rise_evt)
    );

    always_comb begin
        c_d = c_q;
        if (fall_evt)     c_d.cnt = '0;
        else if (tick_en) c_d.cnt = c_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    logic [NUM_CH-1:0] evt_w, en_w, clr_w, flag_w, ovr_w;
    logic [CNT_W-1:0]  cap_w [NUM_CH];

    assign evt_w[CH_FALL] = fall_evt;
    assign evt_w[CH_RISE] = rise_evt;
    assign en_w[CH_FALL]  = cap_en_fall;
    assign en_w[CH_RISE]  = cap_en_rise;
    assign clr_w[CH_FALL] = clr_fall;
    assign clr_w[CH_RISE] = clr_rise;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwcap_channel #(.CNT_W(CNT_W)) u_ch (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (evt_w[g]),
            .en   (en_w[g]),
            .clr  (clr_w[g]),
            .cnt  (c_q.cnt),
            .cap  (cap_w[g]),
            .flag (flag_w[g]),
            .ovr  (ovr_w[g])
        );
    end

    assign cap_fall  = cap_w[CH_FALL];
    assign cap_rise  = cap_w[CH_RISE];
    assign flag_fall = flag_w[CH_FALL];
    assign flag_rise = flag_w[CH_RISE];
    assign ovr_fall  = ovr_w[CH_FALL];
    assign ovr_rise  = ovr_w[CH_RISE];
endmodule

// File: rtl/pwcap_chk.sv
module pwcap_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             fall_evt,
    input logic [CNT_W-1:0] cnt,
    input logic             cap_en_fall,
    input logic             cap_en_rise,
    input logic             clr_rise,
    input logic [CNT_W-1:0] cap_fall,
    input logic [CNT_W-1:0] cap_rise,
    input logic             flag_rise,
    input logic             ovr_rise
);
    assert_trig_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> (cnt == '0));

    assert_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !fall_evt) |=> $stable(cnt));

    assert_tick_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !fall_evt) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_gate_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_rise |=> $stable(cap_rise));

    assert_gate_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_fall |=> $stable(cap_fall));

    assert_flag_on_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_rise) |-> flag_rise);

    assert_clr_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise |=> !ovr_rise);

    assert_ovr_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_rise) |-> $past(flag_rise));
endmodule

bind pwcap_top pwcap_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .fall_evt   (fall_evt),
    .cnt        (c_q.cnt),
    .cap_en_fall(cap_en_fall),
    .cap_en_rise(cap_en_rise),
    .clr_rise   (clr_rise),
    .cap_fall   (cap_fall),
    .cap_rise   (cap_rise),
    .flag_rise  (flag_rise),
    .ovr_rise   (ovr_rise)
);

// File: tb/pwcap_top_test.sv
module pwcap_top_test;
    localparam int CW   = 8;
    localparam int MASK = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1, pin = 1'b1;
    logic en_f = 1'b1, en_r = 1'b1;
    logic mon_clr_f = 1'b0, mon_clr_r = 1'b0, man_clr = 1'b0;
    logic [CW-1:0] cap_fall, cap_rise;
    logic flag_fall, flag_rise, ovr_fall, ovr_rise;

    int q_f[$], q_r[$];
    int checks = 0, errors = 0, cyc = 0, last_fall = -1, e;
    bit mon_on = 1'b1, push_en = 1'b1, done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwcap_top #(.CNT_W(CW), .FILT_LEN(8), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pin_in(pin),
        .cap_en_fall(en_f), .cap_en_rise(en_r),
        .clr_fall(mon_clr_f | man_clr), .clr_rise(mon_clr_r | man_clr),
        .cap_fall(cap_fall), .cap_rise(cap_rise),
        .flag_fall(flag_fall), .flag_rise(flag_rise),
        .ovr_fall(ovr_fall), .ovr_rise(ovr_rise)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expectations as captures appear, then clears flags
    always @(negedge clk) begin
        mon_clr_r = 1'b0;
        mon_clr_f = 1'b0;
        if (rst_n && mon_on) begin
            if (flag_rise) begin
                if (q_r.size() == 0) check(1'b0, "R8 unexpected rise capture", int'(cap_rise), -1);
                else begin
                    e = q_r.pop_front();
                    if (e >= 0) check(int'(cap_rise) == e, "R4 rise width", int'(cap_rise), e);
                end
                mon_clr_r = 1'b1;
            end
            if (flag_fall) begin
                if (q_f.size() == 0) check(1'b0, "R8 unexpected fall capture", int'(cap_fall), -1);
                else begin
                    e = q_f.pop_front();
                    if (e >= 0) check(int'(cap_fall) == e, "R3 fall period", int'(cap_fall), e);
                end
                mon_clr_f = 1'b1;
            end
        end
    end

    task automatic pulse(input int len, input int gap);
        if (push_en && en_f)
            q_f.push_back((last_fall < 0 || !tick_en) ? -1 : ((cyc - last_fall - 1) & MASK));
        last_fall = tick_en ? cyc : -1;
        pin = 1'b0;
        repeat (len) @(negedge clk);
        pin = 1'b1;
        if (push_en && en_r) q_r.push_back(tick_en ? ((len - 1) & MASK) : 0);
        repeat (gap) @(negedge clk);
        if (!tick_en) last_fall = -1;
    endtask

    task automatic spike(input int len);
        pin = 1'b0;
        repeat (len) @(negedge clk);
        pin = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(cap_fall == 0 && cap_rise == 0, "R1 capture regs", int'(cap_rise), 0);
        check({flag_fall, flag_rise, ovr_fall, ovr_rise} == 4'b0, "R1 flags",
              int'({flag_fall, flag_rise, ovr_fall, ovr_rise}), 0);

        pulse(20, 30);     // R4 width 19
        pulse(8, 30);      // R2 boundary accepted, width 7
        check(int'(cap_rise) == 7, "R2 eight-sample pulse", int'(cap_rise), 7);
        prev = int'(cap_rise);
        spike(7);          // R2 rejected spike
        check(int'(cap_rise) == prev, "R2 seven-sample spike rise", int'(cap_rise), prev);
        check(flag_rise == 1'b0 && flag_fall == 1'b0, "R2 spike no flags",
              int'({flag_fall, flag_rise}), 0);
        pulse(12, 25);
        pulse(33, 40);
        pulse(50, 20);
        check(int'(cap_rise) == 49, "R7 rise holds last width", int'(cap_rise), 49);

        // R5 tick gating
        tick_en = 1'b0;
        pulse(20, 30);
        tick_en = 1'b1;
        check(int'(cap_rise) == 0, "R5 no ticks gives zero width", int'(cap_rise), 0);

        // R6 rise channel disabled
        pulse(18, 30);
        prev = int'(cap_rise);
        en_r = 1'b0;
        pulse(15, 30);
        en_r = 1'b1;
        check(int'(cap_rise) == prev, "R6 disabled rise holds", int'(cap_rise), prev);
        check(flag_rise == 1'b0, "R6 disabled rise no flag", int'(flag_rise), 0);

        // R6 fall channel disabled, counter still cleared
        prev = int'(cap_fall);
        en_f = 1'b0;
        pulse(15, 30);
        en_f = 1'b1;
        check(int'(cap_rise) == 14, "R6 counter cleared with fall disabled", int'(cap_rise), 14);
        check(int'(cap_fall) == prev, "R6 disabled fall holds", int'(cap_fall), prev);

        // R10 wrap
        pulse(300, 30);
        check(int'(cap_rise) == (299 & MASK), "R10 wrapped width", int'(cap_rise), 299 & MASK);
        pulse(10, 30);

        // R9 overcapture, monitor paused
        mon_on = 1'b0;
        push_en = 1'b0;
        pulse(10, 30);
        pulse(12, 30);
        check(flag_rise && flag_fall, "R8 flags set by capture", int'({flag_fall, flag_rise}), 3);
        check(ovr_rise == 1'b1, "R9 rise overcapture", int'(ovr_rise), 1);
        check(ovr_fall == 1'b1, "R9 fall overcapture", int'(ovr_fall), 1);
        check(int'(cap_rise) == 11, "R7 latest width kept", int'(cap_rise), 11);
        man_clr = 1'b1;
        @(negedge clk);
        man_clr = 1'b0;
        @(negedge clk);
        check({flag_fall, flag_rise, ovr_fall, ovr_rise} == 4'b0, "R8 clear drops flags",
              int'({flag_fall, flag_rise, ovr_fall, ovr_rise}), 0);
        mon_on = 1'b1;
        push_en = 1'b1;
        pulse(25, 30);
        pulse(9, 30);

        check(q_f.size() == 0 && q_r.size() == 0, "R3 all expected captures seen",
              q_f.size() + q_r.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule